// File: doc/BRIEF.md
# Bus Address Window Translator

This block sits between a host-side 32-bit request stream and a local bus. It holds two address windows: window 0 is a general memory window and window 1 is an expansion ROM window. Each window has a range mask, a host base and a local base. An incoming address that falls inside an enabled window keeps its offset bits, which are the bits cleared in the mask. Its upper bits, which are the bits set in the mask, are replaced by the window's local base. The block then runs a local access for the hit window. It inserts the programmed wait states. It waits for the local ready input if the window enables that input. It ends early if a burst-terminate input is enabled and asserted.

Requests arrive on a valid/ready handshake. `req_ready` is high only while no access is in flight. A request is consumed on the edge where both `req_valid` and `req_ready` are high. A request that hits no window is consumed and flagged as a miss in that same cycle. While an access is busy, `req_ready` stays low and the host must hold or withhold its request. A plain register port programs the eight window registers.

Top module: `addr_window_xlate`

## Requirements
- R1: A window hits when `(addr & mask) == (host_base & mask)` and bit 0 (enable) of its host base register is 1. The mask is the range register with bits 3:0 forced to zero.
- R2: The local address of a hit is `(addr & ~mask) | (local_base & mask)`. It appears on `loc_addr` from the cycle after acceptance until done.
- R3: When both windows hit, window 0 (memory) is used and `loc_win` reads 0. A ROM-only hit gives `loc_win` = 1.
- R4: After reset every register reads 0, except the ROM host base (index 5), which reads 1. The ROM window is therefore enabled, and with its zero mask it matches every address. Writing 0 to index 5 disables the ROM window.
- R5: Register index `cfg_addr` selects a register: 0 is range, 1 is host base, 2 is local base, 3 is descriptor; adding 4 selects window 1 instead of window 0. A write with `cfg_we` takes effect at the next rising edge, and `cfg_rdata` shows the selected register combinationally. A descriptor stores bits 7:0 only.
- R6: The descriptor fields are: bits 1:0 bus width (driven on `loc_width`), bits 5:2 wait count W, bit 6 ready enable, bit 7 burst-terminate enable. With both enables at 0, `loc_done` is high exactly in the (W+1)-th cycle after the accepting edge. `loc_busy` stays high up to and including that cycle.
- R7: With ready enable at 1, `loc_done` rises in the first busy cycle in which at least W+1 cycles have passed and `loc_ready_in` is 1.
- R8: With burst-terminate enable at 1, `loc_bterm_in` high in a busy cycle raises `loc_term` and `loc_done` in that cycle. With the enable at 0, `loc_bterm_in` has no effect on the done cycle and `loc_term` stays 0.
- R9: An accepted request that hits no window raises `req_miss` in its accepting cycle and starts no access: `loc_busy` stays 0.
- R10: `req_ready` is 0 while `loc_busy` is 1. Range register bits 3:0 are type flags (bit 0: I/O space, bits 2:1: placement, bit 3: prefetchable). They are stored but do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Host address |
| req_miss | output | 1 | Accepted request hit no window |
| loc_busy | output | 1 | Local access in flight |
| loc_addr | output | 32 | Translated local address |
| loc_win | output | 1 | Window used by the access |
| loc_width | output | 2 | Bus width field of that window |
| loc_ready_in | input | 1 | Local ready input |
| loc_bterm_in | input | 1 | Local burst-terminate input |
| loc_done | output | 1 | Access completes this cycle |
| loc_term | output | 1 | Access ended by burst-terminate |

## Verification
The assertions assume that `loc_ready_in` and `loc_bterm_in` are free of X whenever an access is busy. They also assume that the host withdraws `req_valid` in the cycle after each accepted request. The bench drives both local inputs to defined values in every cycle. It raises them only in the busy cycle chosen by each scenario, then drops them. It presents each request for exactly one accepting edge and clears `req_valid` at the next falling edge. Register writes happen only while no access is in flight, so the descriptor captured at acceptance is the one the bench expects.

// File: rtl/awx_pkg.sv
package awx_pkg;
  localparam int AW        = 32;
  localparam int NWIN      = 2;
  localparam int WIN_W     = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int WAIT_W    = 4;
  localparam int FLAG_BITS = 4;
  localparam int DESC_W    = 2 + WAIT_W + 2;

  typedef struct packed {
    logic              bterm_en;
    logic              rdy_en;
    logic [WAIT_W-1:0] waits;
    logic [1:0]        width;
  } desc_t;

  typedef struct packed {
    logic [AW-1:0] range;
    logic [AW-1:0] hbase;
    logic [AW-1:0] lbase;
    desc_t         desc;
  } win_cfg_t;

  typedef enum logic { S_IDLE = 1'b0, S_BUSY = 1'b1 } seq_state_t;
endpackage

// File: rtl/awx_regs.sv
module awx_regs
  import awx_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [WIN_W+1:0]          addr,
  input  logic [AW-1:0]             wdata,
  output logic [AW-1:0]             rdata,
  output win_cfg_t [NWIN-1:0]       cfg
);
  localparam int ROM_IDX = NWIN - 1;

  logic [WIN_W-1:0] sel_win;
  logic [1:0]       sel_fld;
  assign sel_win = addr[WIN_W+1:2];
  assign sel_fld = addr[1:0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [AW-1:0] HB_RST = (w == ROM_IDX) ? AW'(1) : '0;
    logic hit_w;
    assign hit_w = we && (sel_win == WIN_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[w].range <= '0;
        cfg[w].hbase <= HB_RST;
        cfg[w].lbase <= '0;
        cfg[w].desc  <= '0;
      end else if (hit_w) begin
        case (sel_fld)
          2'd0:    cfg[w].range <= wdata;
          2'd1:    cfg[w].hbase <= wdata;
          2'd2:    cfg[w].lbase <= wdata;
          default: cfg[w].desc  <= desc_t'(wdata[DESC_W-1:0]);
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel_win == WIN_W'(w)) begin
        case (sel_fld)
          2'd0:    rdata = cfg[w].range;
          2'd1:    rdata = cfg[w].hbase;
          2'd2:    rdata = cfg[w].lbase;
          default: rdata = AW'(cfg[w].desc);
        endcase
      end
    end
  end
endmodule

// File: rtl/awx_decode.sv
module awx_decode
  import awx_pkg::*;
(
  input  win_cfg_t [NWIN-1:0] cfg,
  input  logic [AW-1:0]       addr,
  output logic                hit,
  output logic [WIN_W-1:0]    win,
  output logic [AW-1:0]       xaddr,
  output desc_t               desc
);
  logic [NWIN-1:0]         match;
  logic [NWIN-1:0][AW-1:0] xl;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [AW-1:0] mask_w;
    assign mask_w   = {cfg[w].range[AW-1:FLAG_BITS], {FLAG_BITS{1'b0}}};
    assign match[w] = cfg[w].hbase[0] &&
                      ((addr & mask_w) == (cfg[w].hbase & mask_w));
    assign xl[w]    = (addr & ~mask_w) | (cfg[w].lbase & mask_w);
  end

  // lowest window index has priority
  always_comb begin
    hit   = 1'b0;
    win   = '0;
    xaddr = '0;
    desc  = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit   = 1'b1;
        win   = WIN_W'(w);
        xaddr = xl[w];
        desc  = cfg[w].desc;
      end
    end
  end
endmodule

// File: rtl/awx_seq.sv
module awx_seq
  import awx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    xaddr_in,
  input  logic [WIN_W-1:0] win_in,
  input  desc_t            desc_in,
  input  logic             ready_in,
  input  logic             bterm_in,
  output logic             busy,
  output logic [AW-1:0]    xaddr,
  output logic [WIN_W-1:0] win,
  output desc_t            act,
  output logic             done,
  output logic             term
);
  seq_state_t        state;
  logic [WAIT_W-1:0] cnt;

  assign busy = (state == S_BUSY);
  assign term = busy && act.bterm_en && bterm_in;
  assign done = busy && (term || ((cnt == '0) && (!act.rdy_en || ready_in)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      xaddr <= '0;
      win   <= '0;
      act   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_BUSY;
          cnt   <= desc_in.waits;
          xaddr <= xaddr_in;
          win   <= win_in;
          act   <= desc_in;
        end
        default: begin
          if (done)            state <= S_IDLE;
          else if (cnt != '0)  cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import awx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [WIN_W+1:0]    cfg_addr,
  input  logic [AW-1:0]       cfg_wdata,
  output logic [AW-1:0]       cfg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  output logic                req_miss,
  output logic                loc_busy,
  output logic [AW-1:0]       loc_addr,
  output logic [WIN_W-1:0]    loc_win,
  output logic [1:0]          loc_width,
  input  logic                loc_ready_in,
  input  logic                loc_bterm_in,
  output logic                loc_done,
  output logic                loc_term
);
  win_cfg_t [NWIN-1:0] cfg;
  logic                dec_hit;
  logic [WIN_W-1:0]    dec_win;
  logic [AW-1:0]       dec_addr;
  desc_t               dec_desc;
  desc_t               act;
  logic                accept;
  logic                act_rdy_en;
  logic                act_bterm_en;

  awx_regs i_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  awx_decode i_dec (
    .cfg(cfg), .addr(req_addr), .hit(dec_hit), .win(dec_win),
    .xaddr(dec_addr), .desc(dec_desc)
  );

  assign req_ready = !loc_busy;
  assign accept    = req_valid && req_ready;
  assign req_miss  = accept && !dec_hit;

  awx_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && dec_hit),
    .xaddr_in(dec_addr), .win_in(dec_win), .desc_in(dec_desc),
    .ready_in(loc_ready_in), .bterm_in(loc_bterm_in),
    .busy(loc_busy), .xaddr(loc_addr), .win(loc_win), .act(act),
    .done(loc_done), .term(loc_term)
  );

  assign loc_width    = act.width;
  assign act_rdy_en   = act.rdy_en;
  assign act_bterm_en = act.bterm_en;
endmodule

// File: rtl/awx_checker.sv
module awx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        req_miss,
  input logic        loc_busy,
  input logic        loc_done,
  input logic        loc_term,
  input logic        loc_ready_in,
  input logic        loc_bterm_in,
  input logic [31:0] loc_addr,
  input logic        act_rdy_en,
  input logic        act_bterm_en
);
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_busy |-> !req_ready);

  p_term_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loc_term |-> (loc_done && act_bterm_en && loc_bterm_in));

  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_done && !loc_term && act_rdy_en) |-> loc_ready_in);

  p_miss_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_miss |=> !loc_busy);

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_busy && !loc_done) |=> (loc_busy && $stable(loc_addr)));

  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_done |=> !loc_busy);
endmodule

bind addr_window_xlate awx_checker i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_miss(req_miss),
  .loc_busy(loc_busy), .loc_done(loc_done), .loc_term(loc_term),
  .loc_ready_in(loc_ready_in), .loc_bterm_in(loc_bterm_in),
  .loc_addr(loc_addr), .act_rdy_en(act_rdy_en), .act_bterm_en(act_bterm_en)
);

// File: tb/test_addr_window_xlate.sv
`timescale 1ns/1ps
module test_addr_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_miss;
  logic        loc_busy;
  logic [31:0] loc_addr;
  logic        loc_win;
  logic [1:0]  loc_width;
  logic        loc_ready_in = 1'b0;
  logic        loc_bterm_in = 1'b0;
  logic        loc_done;
  logic        loc_term;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_window_xlate i_addr_window_xlate (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // one request; n = busy cycle index of done (1 = cycle after accept)
  task automatic access(input logic [31:0] a, input int rdy_at, input int bt_at,
                        output int n, output logic [31:0] la, output logic w,
                        output logic t, output logic missed, output logic stall);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; loc_ready_in = 1'b0; loc_bterm_in = 1'b0;
    #1;
    missed = req_miss;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; la = '0; w = 1'b0; t = 1'b0; stall = 1'b0;
    if (missed) return;
    n = 1;
    forever begin
      loc_ready_in = (rdy_at > 0) && (n >= rdy_at);
      loc_bterm_in = (n == bt_at);
      #1;
      if (n == 1) stall = !req_ready && loc_busy;
      if (loc_done) begin
        la = loc_addr; w = loc_win; t = loc_term;
        break;
      end
      @(negedge clk);
      n++;
      if (n > 100) break;
    end
    @(negedge clk);
    loc_ready_in = 1'b0; loc_bterm_in = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    for (int i = 0; i < 8; i++)
      rd_check("R4 reset reg", 3'(i), (i == 5) ? 32'h1 : 32'h0);
    check("R4 reset ready", {31'b0, req_ready}, 32'h1);
    check("R4 reset busy", {31'b0, loc_busy}, 32'h0);
  endtask

  task automatic t_rom_default;
    int n; logic [31:0] la; logic w, t, m, s;
    access(32'h1234_5678, 0, 0, n, la, w, t, m, s);
    check("R4 rom default hit", {31'b0, m}, 32'h0);
    check("R4 rom default win", {31'b0, w}, 32'h1);
    check("R2 rom zero mask addr", la, 32'h1234_5678);
    check("R6 zero waits", n, 1);
  endtask

  task automatic t_mem_window;
    int n; logic [31:0] la; logic w, t, m, s;
    wr(3'd0, 32'hFF80_0000);
    wr(3'd1, 32'h4000_0001);
    wr(3'd2, 32'hA000_0000);
    wr(3'd3, 32'hFFFF_FF0B);
    rd_check("R5 range readback", 3'd0, 32'hFF80_0000);
    rd_check("R5 lbase readback", 3'd2, 32'hA000_0000);
    rd_check("R5 desc 8 bits", 3'd3, 32'h0000_000B);
    access(32'h4012_3456, 0, 0, n, la, w, t, m, s);
    check("R1 mem hit", {31'b0, m}, 32'h0);
    check("R3 mem win", {31'b0, w}, 32'h0);
    check("R2 mem translate", la, 32'hA012_3456);
    check("R6 two waits", n, 3);
    check("R10 stall while busy", {31'b0, s}, 32'h1);
  endtask

  task automatic t_width;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h4000_0010;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 width out", {30'b0, loc_width}, 32'h3);
    while (loc_busy) @(negedge clk);
  endtask

  task automatic t_miss;
    int n; logic [31:0] la; logic w, t, m, s;
    wr(3'd5, 32'h0);
    rd_check("R4 rom disabled", 3'd5, 32'h0);
    access(32'h5000_0000, 0, 0, n, la, w, t, m, s);
    check("R9 miss flag", {31'b0, m}, 32'h1);
    check("R9 no busy", {31'b0, loc_busy}, 32'h0);
    wr(3'd0, 32'hFF80_000F);
    access(32'h407F_FFF0, 0, 0, n, la, w, t, m, s);
    check("R10 flags ignored hit", {31'b0, m}, 32'h0);
    check("R10 flags ignored addr", la, 32'hA07F_FFF0);
    access(32'h4080_0000, 0, 0, n, la, w, t, m, s);
    check("R1 outside window miss", {31'b0, m}, 32'h1);
  endtask

  task automatic t_rom_ready;
    int n; logic [31:0] la; logic w, t, m, s;
    wr(3'd4, 32'hFFFF_0000);
    wr(3'd5, 32'h000C_0001);
    wr(3'd6, 32'h1FFF_0000);
    wr(3'd7, 32'h0000_0043);
    access(32'h000C_1234, 4, 0, n, la, w, t, m, s);
    check("R3 rom win", {31'b0, w}, 32'h1);
    check("R2 rom translate", la, 32'h1FFF_1234);
    check("R7 ready gating", n, 4);
    wr(3'd7, 32'h0000_004B);
    access(32'h000C_0004, 1, 0, n, la, w, t, m, s);
    check("R7 waits before ready", n, 3);
  endtask

  task automatic t_priority;
    int n; logic [31:0] la; logic w, t, m, s;
    wr(3'd5, 32'h4000_0001);
    access(32'h4000_1234, 0, 0, n, la, w, t, m, s);
    check("R3 priority win", {31'b0, w}, 32'h0);
    check("R3 priority addr", la, 32'hA000_1234);
  endtask

  task automatic t_bterm;
    int n; logic [31:0] la; logic w, t, m, s;
    wr(3'd3, 32'h0000_0097);
    access(32'h4000_0020, 0, 3, n, la, w, t, m, s);
    check("R8 bterm cycle", n, 3);
    check("R8 bterm flag", {31'b0, t}, 32'h1);
    wr(3'd3, 32'h0000_0017);
    access(32'h4000_0020, 0, 3, n, la, w, t, m, s);
    check("R8 bterm ignored cycle", n, 6);
    check("R8 bterm ignored flag", {31'b0, t}, 32'h0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_default();
    t_mem_window();
    t_width();
    t_miss();
    t_rom_ready();
    t_priority();
    t_bterm();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule